// File: doc/BRIEF.md
# Flash Address-Space Overlay Controller

This block selects what a parallel NOR flash returns on its read data bus. A host drives chip enable, output enable, write enable, a word address and a command byte. Single-cycle command writes move the block between four modes: plain array read, data polling, status-register read and overlay. In overlay mode the chosen table (identification, one-time-programmable secure words or protection words) replaces the entire address range. Words outside the table's defined size return a fixed filler word.

The embedded program and erase algorithms are not part of the block. They appear only as a `busy` input and a `suspended` input. The algorithm counts as running when `busy` is high and `suspended` is low. While it runs, reads return a polling word. When it is suspended, the bus falls back to array read, and only a reduced set of commands is accepted.

A status-read command is accepted from every mode. It places the status word at every address and records the mode it interrupted. The next completed read restores that mode. The bus strobes are sampled on `clk`. A write completes when `wr_n` rises while `ce_n` is low. A read completes when `rd_n` rises while `ce_n` is low.

Top module: `flash_aso_ctrl`

## Requirements
- R1: After reset the mode output is 0 (array read), and `dout` shows the array word for the current address.
- R2: In array-read mode (mode 0), `dout` equals the zero-extended address XOR 16'hC3C3, at any address.
- R3: In mode 0, a write of 0x90, 0x88 or 0x40 at word address 0x555 enters overlay mode (mode 3) with the identification, secure or protection table. The table covers the whole range. Identification word a (a < 16) is 16'h0100 + a. Secure word a (a < 32) is 16'hE000 | a. Protection word a (a < 8) is 16'h8000 >> a. Every other address returns 16'hFFFF.
- R4: A write of 0xF0 at any address leaves overlay mode and returns to mode 0.
- R5: A write of 0x70 at address 0x555 enters status mode (mode 2) from any mode. In status mode every address returns {8'h00, ready, suspended, 6'b0}, where ready is high unless the algorithm is running.
- R6: In status mode, every write is ignored, including 0xF0 and overlay entry commands.
- R7: The first completed read in status mode returns the status word and then restores the mode that was active when 0x70 arrived, including the selected overlay table.
- R8: When the algorithm starts running in mode 0, the mode becomes 1. Each completed read in mode 1 flips bit 6 of the polling word {8'h00, 1'b0, toggle, 6'b0}. The toggle starts at 0. Commands other than 0x70 are ignored in mode 1. When the algorithm stops running, the mode returns to 0.
- R9: Suspending a running algorithm returns the bus to mode 0. While suspended, the identification entry, status read and 0xF0 commands are accepted, and the secure and protection entries are ignored. Resuming brings back mode 1.
- R10: Hardware reset overrides everything, including status mode with a pending return. A read after reset leaves the mode at 0.
- R11: If the algorithm starts or stops while status mode is active, the mode restored by the closing read follows that change (0 becomes 1 on start, 1 becomes 0 on stop).
- R12: Strobe edges while `ce_n` is high have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Output enable, active low; rising edge ends a read |
| wr_n | input | 1 | Write enable, active low; rising edge ends a write |
| addr | input | AW (12) | Word address |
| cmd_data | input | 8 | Command byte for writes |
| busy | input | 1 | Embedded algorithm in progress |
| suspended | input | 1 | Embedded algorithm suspended |
| dout | output | DW (16) | Read data |
| mode | output | 2 | 0 read, 1 polling, 2 status, 3 overlay |

## Verification
The hardest case is an algorithm state change that lands between the status-read command and its closing read. In that case the saved return mode must be rewritten, not just restored. The bench reaches it by entering polling, issuing 0x70, and dropping `busy` while status mode holds. It also runs the reverse order: it issues 0x70 from mode 0 and raises `busy` before the read. In both orders the bench checks the mode that comes back after the read.

// File: rtl/flash_aso_pkg.sv
package flash_aso_pkg;
  typedef enum logic [1:0] {
    M_READ = 2'd0,
    M_POLL = 2'd1,
    M_SR   = 2'd2,
    M_ASO  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OV_ID   = 2'd0,
    OV_SSR  = 2'd1,
    OV_PROT = 2'd2
  } ovl_e;

  typedef enum logic [2:0] {
    C_NONE = 3'd0,
    C_SR   = 3'd1,
    C_RST  = 3'd2,
    C_ID   = 3'd3,
    C_SSR  = 3'd4,
    C_PROT = 3'd5
  } cmd_e;

  localparam logic [7:0] OP_SR   = 8'h70;
  localparam logic [7:0] OP_RST  = 8'hF0;
  localparam logic [7:0] OP_ID   = 8'h90;
  localparam logic [7:0] OP_SSR  = 8'h88;
  localparam logic [7:0] OP_PROT = 8'h40;
endpackage

// File: rtl/flash_aso_bus_dec.sv
module flash_aso_bus_dec
  import flash_aso_pkg::*;
#(
  parameter int          AW     = 12,
  parameter logic [AW-1:0] UNLOCK = 12'h555
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    cmd_data,
  output logic          wr_done,
  output logic          rd_done,
  output cmd_e          cmd
);
  logic wr_q, rd_q;
  logic wr_d, rd_d;

  always_comb begin
    wr_d = wr_n;
    rd_d = rd_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  assign wr_done = ~wr_q & wr_n & ~ce_n;
  assign rd_done = ~rd_q & rd_n & ~ce_n;

  always_comb begin
    cmd = C_NONE;
    if (cmd_data == OP_RST) begin
      cmd = C_RST;
    end else if (addr == UNLOCK) begin
      unique case (cmd_data)
        OP_SR:   cmd = C_SR;
        OP_ID:   cmd = C_ID;
        OP_SSR:  cmd = C_SSR;
        OP_PROT: cmd = C_PROT;
        default: cmd = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/flash_aso_mode_fsm.sv
module flash_aso_mode_fsm
  import flash_aso_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_done,
  input  logic  rd_done,
  input  cmd_e  cmd,
  input  logic  busy,
  input  logic  suspended,
  output mode_e mode_o,
  output ovl_e  ovl_o,
  output logic  tog_o,
  output logic  act_o
);
  mode_e mode_q, mode_d, saved_q, saved_d;
  ovl_e  ovl_q, ovl_d;
  logic  tog_q, tog_d;
  logic  act, act_q, act_rise, act_fall;

  assign act      = busy & ~suspended;
  assign act_rise = act & ~act_q;
  assign act_fall = ~act & act_q;

  always_comb begin
    mode_d  = mode_q;
    saved_d = saved_q;
    ovl_d   = ovl_q;
    tog_d   = tog_q;
    if (mode_q == M_SR) begin
      if (rd_done) mode_d = saved_q;
    end else begin
      if (mode_q == M_POLL && rd_done) tog_d = ~tog_q;
      if (wr_done) begin
        if (cmd == C_SR) begin
          saved_d = mode_q;
          mode_d  = M_SR;
        end else if (cmd == C_RST && mode_q == M_ASO) begin
          mode_d = M_READ;
        end else if (mode_q == M_READ && cmd == C_ID) begin
          mode_d = M_ASO;
          ovl_d  = OV_ID;
        end else if (mode_q == M_READ && !suspended && cmd == C_SSR) begin
          mode_d = M_ASO;
          ovl_d  = OV_SSR;
        end else if (mode_q == M_READ && !suspended && cmd == C_PROT) begin
          mode_d = M_ASO;
          ovl_d  = OV_PROT;
        end
      end
    end
    // algorithm state changes re-target the live or the saved mode
    if (act_rise) begin
      if (mode_d == M_READ) begin
        mode_d = M_POLL;
        tog_d  = 1'b0;
      end else if (mode_d == M_SR && saved_d == M_READ) begin
        saved_d = M_POLL;
        tog_d   = 1'b0;
      end
    end
    if (act_fall) begin
      if (mode_d == M_POLL) mode_d = M_READ;
      else if (mode_d == M_SR && saved_d == M_POLL) saved_d = M_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_READ;
      saved_q <= M_READ;
      ovl_q   <= OV_ID;
      tog_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      saved_q <= saved_d;
      ovl_q   <= ovl_d;
      tog_q   <= tog_d;
      act_q   <= act;
    end
  end

  assign mode_o = mode_q;
  assign ovl_o  = ovl_q;
  assign tog_o  = tog_q;
  assign act_o  = act;

  p_sr_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SR && rd_done && !act_rise && !act_fall) |=> mode_q == $past(saved_q));
  p_sr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SR && !rd_done) |=> mode_q == M_SR);
  p_rst_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ASO && wr_done && cmd == C_RST) |=> mode_q == M_READ);
  p_susp_filter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_READ && suspended && wr_done && (cmd == C_SSR || cmd == C_PROT))
      |=> mode_q == M_READ);
  p_poll_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_READ && act_rise && !wr_done) |=> mode_q == M_POLL);
endmodule

// File: rtl/flash_aso_read_mux.sv
module flash_aso_read_mux
  import flash_aso_pkg::*;
#(
  parameter int          AW        = 12,
  parameter int          DW        = 16,
  parameter int          ID_WORDS  = 16,
  parameter int          SSR_WORDS = 32,
  parameter int          PRT_WORDS = 8,
  parameter logic [DW-1:0] FILL    = 16'hFFFF
) (
  input  mode_e          mode,
  input  ovl_e           ovl,
  input  logic [AW-1:0]  addr,
  input  logic           tog,
  input  logic           act,
  input  logic           suspended,
  output logic [DW-1:0]  dout
);
  localparam int PAD = DW - 8;
  localparam logic [DW-1:0] MAIN_KEY = DW'(16'hC3C3);

  logic [DW-1:0] main_w, id_w, ssr_w, prt_w, stat_w, poll_w, ovl_w;
  logic          in_id, in_ssr, in_prt;

  assign in_id  = int'(addr) < ID_WORDS;
  assign in_ssr = int'(addr) < SSR_WORDS;
  assign in_prt = int'(addr) < PRT_WORDS;

  assign main_w = DW'(addr) ^ MAIN_KEY;
  assign id_w   = in_id  ? DW'(16'h0100) + DW'(addr) : FILL;
  assign ssr_w  = in_ssr ? DW'(16'hE000) | DW'(addr) : FILL;
  assign prt_w  = in_prt ? DW'(16'h8000) >> addr : FILL;
  assign stat_w = {{PAD{1'b0}}, ~act, suspended, 6'b0};
  assign poll_w = {{PAD{1'b0}}, 1'b0, tog, 6'b0};

  always_comb begin
    unique case (ovl)
      OV_SSR:  ovl_w = ssr_w;
      OV_PROT: ovl_w = prt_w;
      default: ovl_w = id_w;
    endcase
  end

  always_comb begin
    unique case (mode)
      M_POLL:  dout = poll_w;
      M_SR:    dout = stat_w;
      M_ASO:   dout = ovl_w;
      default: dout = main_w;
    endcase
  end
endmodule

// File: rtl/flash_aso_ctrl.sv
module flash_aso_ctrl
  import flash_aso_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    cmd_data,
  input  logic          busy,
  input  logic          suspended,
  output logic [DW-1:0] dout,
  output logic [1:0]    mode
);
  logic  rst_s1, rst_sn;
  logic  wr_done, rd_done, tog, act;
  cmd_e  cmd;
  mode_e mode_w;
  ovl_e  ovl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  flash_aso_bus_dec #(.AW(AW), .UNLOCK(AW'(12'h555))) u_dec (
    .clk(clk), .rst_n(rst_sn), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .cmd_data(cmd_data),
    .wr_done(wr_done), .rd_done(rd_done), .cmd(cmd)
  );

  flash_aso_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn), .wr_done(wr_done), .rd_done(rd_done),
    .cmd(cmd), .busy(busy), .suspended(suspended),
    .mode_o(mode_w), .ovl_o(ovl), .tog_o(tog), .act_o(act)
  );

  flash_aso_read_mux #(.AW(AW), .DW(DW)) u_mux (
    .mode(mode_w), .ovl(ovl), .addr(addr), .tog(tog), .act(act),
    .suspended(suspended), .dout(dout)
  );

  assign mode = mode_w;
endmodule

// File: tb/test_flash_aso_ctrl.sv
`timescale 1ns/1ps
module test_flash_aso_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, rd_n, wr_n, busy, suspended;
  logic [11:0] addr;
  logic [7:0]  cmd_data;
  logic [15:0] dout;
  logic [1:0]  mode;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  flash_aso_ctrl i_flash_aso_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .cmd_data(cmd_data), .busy(busy), .suspended(suspended),
    .dout(dout), .mode(mode)
  );

  function automatic logic [15:0] main_x(input logic [11:0] a);
    return {4'h0, a} ^ 16'hC3C3;
  endfunction
  function automatic logic [15:0] stat_x(input logic run, input logic sus);
    return {8'h00, ~run, sus, 6'b0};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk); ce_n = sel_n; addr = a; cmd_data = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [15:0] v, input logic sel_n = 1'b0);
    @(negedge clk); ce_n = sel_n; addr = a; rd_n = 1'b0;
    @(negedge clk); v = dout; rd_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic peek(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk); addr = a;
    #1 v = dout;
  endtask

  task automatic set_alg(input logic b, input logic s);
    @(negedge clk); busy = b; suspended = s;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; cmd_data = '0; busy = 1'b0; suspended = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    chk("R1 mode", {14'b0, mode}, 16'd0);
    peek(12'h123, v); chk("R1 dout", v, main_x(12'h123));
  endtask

  task automatic t_read();
    logic [15:0] v;
    peek(12'h000, v); chk("R2 a0", v, main_x(12'h000));
    peek(12'hFFF, v); chk("R2 aFFF", v, main_x(12'hFFF));
    bus_rd(12'h555, v); chk("R2 read", v, main_x(12'h555));
  endtask

  task automatic t_overlays();
    logic [15:0] v;
    bus_wr(12'h555, 8'h90); chk("R3 id mode", {14'b0, mode}, 16'd3);
    peek(12'h000, v); chk("R3 id0", v, 16'h0100);
    peek(12'h00F, v); chk("R3 id15", v, 16'h010F);
    peek(12'h010, v); chk("R3 id fill", v, 16'hFFFF);
    peek(12'h555, v); chk("R3 id fill hi", v, 16'hFFFF);
    bus_wr(12'h0AB, 8'hF0); chk("R4 exit id", {14'b0, mode}, 16'd0);
    bus_wr(12'h555, 8'h88); chk("R3 ssr mode", {14'b0, mode}, 16'd3);
    peek(12'h01F, v); chk("R3 ssr31", v, 16'hE01F);
    peek(12'h020, v); chk("R3 ssr fill", v, 16'hFFFF);
    bus_wr(12'h7FF, 8'hF0); chk("R4 exit ssr", {14'b0, mode}, 16'd0);
    bus_wr(12'h555, 8'h40);
    peek(12'h003, v); chk("R3 prot3", v, 16'h1000);
    peek(12'h008, v); chk("R3 prot fill", v, 16'hFFFF);
    bus_wr(12'h000, 8'hF0); chk("R4 exit prot", {14'b0, mode}, 16'd0);
  endtask

  task automatic t_status();
    logic [15:0] v;
    bus_wr(12'h555, 8'h90);
    bus_wr(12'h555, 8'h70); chk("R5 sr mode", {14'b0, mode}, 16'd2);
    peek(12'h000, v); chk("R5 any addr 0", v, stat_x(1'b0, 1'b0));
    peek(12'hABC, v); chk("R5 any addr ABC", v, stat_x(1'b0, 1'b0));
    bus_wr(12'h123, 8'hF0); chk("R6 F0 ignored", {14'b0, mode}, 16'd2);
    bus_wr(12'h555, 8'h40); chk("R6 entry ignored", {14'b0, mode}, 16'd2);
    bus_rd(12'h003, v); chk("R7 read value", v, 16'h0080);
    chk("R7 back to overlay", {14'b0, mode}, 16'd3);
    peek(12'h003, v); chk("R7 id table kept", v, 16'h0103);
    bus_wr(12'h000, 8'hF0);
  endtask

  task automatic t_ce_high();
    logic [15:0] v;
    bus_wr(12'h555, 8'h90, 1'b1); chk("R12 write ignored", {14'b0, mode}, 16'd0);
    bus_wr(12'h555, 8'h70);
    bus_rd(12'h000, v, 1'b1); chk("R12 read ignored", {14'b0, mode}, 16'd2);
    bus_rd(12'h000, v); chk("R12 read closes", {14'b0, mode}, 16'd0);
  endtask

  task automatic t_poll();
    logic [15:0] v;
    set_alg(1'b1, 1'b0); chk("R8 poll entry", {14'b0, mode}, 16'd1);
    bus_rd(12'h100, v); chk("R8 first toggle", v, 16'h0000);
    bus_rd(12'h100, v); chk("R8 second toggle", v, 16'h0040);
    bus_wr(12'h555, 8'hF0); chk("R8 F0 ignored", {14'b0, mode}, 16'd1);
    bus_wr(12'h555, 8'h90); chk("R8 entry ignored", {14'b0, mode}, 16'd1);
    set_alg(1'b0, 1'b0); chk("R8 poll exit", {14'b0, mode}, 16'd0);
  endtask

  task automatic t_suspend();
    logic [15:0] v;
    set_alg(1'b1, 1'b0);
    set_alg(1'b1, 1'b1); chk("R9 suspend read", {14'b0, mode}, 16'd0);
    bus_wr(12'h555, 8'h88); chk("R9 ssr refused", {14'b0, mode}, 16'd0);
    bus_wr(12'h555, 8'h40); chk("R9 prot refused", {14'b0, mode}, 16'd0);
    bus_wr(12'h555, 8'h70);
    peek(12'h000, v); chk("R9 status suspended", v, stat_x(1'b0, 1'b1));
    bus_rd(12'h000, v);
    bus_wr(12'h555, 8'h90); chk("R9 id allowed", {14'b0, mode}, 16'd3);
    bus_wr(12'h555, 8'hF0); chk("R9 reset allowed", {14'b0, mode}, 16'd0);
    set_alg(1'b1, 1'b0); chk("R9 resume poll", {14'b0, mode}, 16'd1);
    set_alg(1'b0, 1'b0);
  endtask

  task automatic t_sr_retarget();
    logic [15:0] v;
    set_alg(1'b1, 1'b0);
    bus_wr(12'h555, 8'h70);
    peek(12'h042, v); chk("R5 status busy", v, stat_x(1'b1, 1'b0));
    set_alg(1'b0, 1'b0); chk("R11 still status", {14'b0, mode}, 16'd2);
    bus_rd(12'h042, v); chk("R11 status ready", v, 16'h0080);
    chk("R11 stop retarget", {14'b0, mode}, 16'd0);
    bus_wr(12'h555, 8'h70);
    set_alg(1'b1, 1'b0); chk("R11 start in status", {14'b0, mode}, 16'd2);
    bus_rd(12'h000, v); chk("R11 start retarget", {14'b0, mode}, 16'd1);
    set_alg(1'b0, 1'b0);
  endtask

  task automatic t_hw_reset();
    logic [15:0] v;
    bus_wr(12'h555, 8'h90);
    bus_wr(12'h555, 8'h70);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R10 reset overrides", {14'b0, mode}, 16'd0);
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(12'h010, v); chk("R10 read after reset", v, main_x(12'h010));
    chk("R10 saved cleared", {14'b0, mode}, 16'd0);
  endtask

  initial begin
    t_reset();
    t_read();
    t_overlays();
    t_status();
    t_ce_high();
    t_poll();
    t_suspend();
    t_sr_retarget();
    t_hw_reset();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule